// File: doc/BRIEF.md
# Prescaled Compare Timer

An up-counting timer of 8 or 16 bits. It advances at a rate picked by a 3-bit clock-select code through a prescaler. Two compare registers are checked against every new counter value. Overflow and compare events latch into a three-bit event register. A mask register and a global enable gate these events into one prioritised interrupt request. The request carries a source code, and acknowledging it clears the matching event bit.

All state is reached through a flat register bus. Writes take effect on the clock edge where `wr_en_i` is high. Reads are combinational on `addr_i`. The register addresses are: 0 mode-low (bits 1:0), 1 clock control (bits 2:0 clock select, bit 3 mode bit 2), 2 counter, 3 compare A, 4 compare B, 5 events (bit 0 overflow, bit 1 compare A, bit 2 compare B), 6 mask (same bit positions as the events). Address 7 reads zero.

A parameter selects one of two divider tables. A second parameter sets the counter width.

Top module: `tmr_core`

## Requirements
- R1: After reset every register reads zero and `irq_valid_o` is low. A read returns only the stored bits, zero-extended: 2 bits at address 0, 4 bits at address 1, 3 bits at addresses 5 and 6, and the full width at addresses 2 to 4.
- R2: With the standard table, clock-select codes 1 to 5 advance the counter once every 1, 8, 64, 256 and 1024 cycles. Codes 0, 6 and 7 hold the counter.
- R3: A change of the clock-select code restarts the prescale count. After a write that changes the code, the first increment comes N+1 edges after the write edge, where N is the new divider.
- R4: The mode is {addr1 bit 3, addr0 bits 1:0}. In modes 0, 1 and 3, an increment from the all-ones value to zero sets event bit 0. No other mode sets bit 0 on a wrap.
- R5: When a new counter value equals a nonzero compare A, event bit 1 is set. Compare A holding zero never matches.
- R6: When a new counter value equals a nonzero compare B, event bit 2 is set. Compare B holding zero never matches.
- R7: In mode 2, a compare A match loads zero into the counter instead of the matching value and also sets event bit 0.
- R8: A bus write to the counter loads the value on the next edge, wins over a prescaler increment in the same cycle, and runs the compare checks on the written value.
- R9: Writing the event register clears each bit written as 1 and leaves bits written as 0 unchanged. A new event on the same edge wins over a clear.
- R10: `irq_valid_o` is high only when some event bit, its mask bit and `gie_i` are all set.
- R11: `irq_sel_o` names the pending source as 0 for overflow, 1 for compare A and 2 for compare B. Overflow has priority over compare A, and compare A over compare B.
- R12: `irq_ack_i` high while `irq_valid_o` is high clears only the event bit named by `irq_sel_o`, on that edge.
- R13: With the alternate table, codes 0 to 7 divide by 1, 1, 8, 32, 64, 128, 256 and 1024, so code 0 counts every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | CNT_W | Write data |
| rdata_o | output | CNT_W | Read data for `addr_i` (combinational) |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Acknowledge of the presented request |
| irq_valid_o | output | 1 | Interrupt request |
| irq_sel_o | output | 2 | Source code of the request |

## Verification
Register writes, counter loads, event sets and acknowledge clears all become visible one edge after the cycle that causes them. `rdata_o`, `irq_valid_o` and `irq_sel_o` follow the stored state combinationally, with no further delay. A prescaler divider of N moves the counter once every N edges, and the first step after a code change comes at edge N+1. The bench drives inputs on falling edges. It advances a cycle-level reference on the rising edge and compares every output a quarter period later, so each result is checked on the exact edge it is due.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] A_MODE_LO = 3'd0;
  localparam logic [2:0] A_CLK_CTL = 3'd1;
  localparam logic [2:0] A_COUNT   = 3'd2;
  localparam logic [2:0] A_CMP_A   = 3'd3;
  localparam logic [2:0] A_CMP_B   = 3'd4;
  localparam logic [2:0] A_EVENTS  = 3'd5;
  localparam logic [2:0] A_MASK    = 3'd6;

  localparam int N_EV   = 3;
  localparam int EV_OVF = 0;
  localparam int EV_CA  = 1;
  localparam int EV_CB  = 2;

  localparam logic [2:0] M_NORMAL = 3'd0;
  localparam logic [2:0] M_PWM_PC = 3'd1;
  localparam logic [2:0] M_CTC    = 3'd2;
  localparam logic [2:0] M_PWM_FS = 3'd3;

  localparam int DIV_W = 11;

  function automatic logic [DIV_W-1:0] div_std(input logic [2:0] cs);
    case (cs)
      3'd1:    return DIV_W'(1);
      3'd2:    return DIV_W'(8);
      3'd3:    return DIV_W'(64);
      3'd4:    return DIV_W'(256);
      3'd5:    return DIV_W'(1024);
      default: return '0;
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] div_alt(input logic [2:0] cs);
    case (cs)
      3'd0, 3'd1: return DIV_W'(1);
      3'd2:       return DIV_W'(8);
      3'd3:       return DIV_W'(32);
      3'd4:       return DIV_W'(64);
      3'd5:       return DIV_W'(128);
      3'd6:       return DIV_W'(256);
      default:    return DIV_W'(1024);
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter bit ALT_TABLE = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] cs_i,
  output logic       tick_o
);
  logic [DIV_W-1:0] div;
  logic [DIV_W-1:0] pc_q;
  logic [2:0]       cs_q;
  logic             run;

  generate
    if (ALT_TABLE) begin : g_alt
      assign div = div_alt(cs_i);
    end else begin : g_std
      assign div = div_std(cs_i);
    end
  endgenerate

  // a code change costs one cycle of restart
  assign run    = (div != '0) && (cs_i == cs_q);
  assign tick_o = run && (pc_q == div - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      cs_q <= '0;
    end else begin
      cs_q <= cs_i;
      pc_q <= (!run || tick_o) ? '0 : pc_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_count_unit.sv
module tmr_count_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  input  logic [2:0]       mode_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [N_EV-1:0]  set_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, nxt;
  logic upd, wrap, hit_a, hit_b, ctc, ovf_mode;

  always_comb begin
    upd      = load_i || tick_i;
    nxt      = load_i ? load_val_i : cnt_q + 1'b1;
    wrap     = !load_i && tick_i && (cnt_q == CNT_MAX);
    hit_a    = upd && (cmp_a_i != '0) && (nxt == cmp_a_i);
    hit_b    = upd && (cmp_b_i != '0) && (nxt == cmp_b_i);
    ctc      = (mode_i == M_CTC);
    ovf_mode = (mode_i == M_NORMAL) || (mode_i == M_PWM_PC) || (mode_i == M_PWM_FS);
    set_o         = '0;
    set_o[EV_OVF] = (wrap && ovf_mode) || (hit_a && ctc);
    set_o[EV_CA]  = hit_a;
    set_o[EV_CB]  = hit_b;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (upd) cnt_q <= (hit_a && ctc) ? '0 : nxt;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
  import tmr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_EV-1:0] set_i,
  input  logic [N_EV-1:0] bus_clr_i,
  input  logic [N_EV-1:0] mask_i,
  input  logic            gie_i,
  input  logic            ack_i,
  output logic [N_EV-1:0] flags_o,
  output logic            irq_valid_o,
  output logic [1:0]      irq_sel_o
);
  logic [N_EV-1:0] flags_q, pend, ack_clr;
  logic [1:0]      sel;

  assign pend = flags_q & mask_i & {N_EV{gie_i}};

  // lowest index wins
  always_comb begin
    sel = '0;
    for (int i = N_EV - 1; i >= 0; i--) begin
      if (pend[i]) sel = 2'(i);
    end
  end

  generate
    for (genvar g = 0; g < N_EV; g++) begin : g_ack
      assign ack_clr[g] = ack_i && (|pend) && (sel == 2'(g));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= set_i | (flags_q & ~(bus_clr_i | ack_clr));
  end

  assign flags_o     = flags_q;
  assign irq_valid_o = |pend;
  assign irq_sel_o   = sel;
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter bit ALT_TABLE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic             gie_i,
  input  logic             irq_ack_i,
  output logic             irq_valid_o,
  output logic [1:0]       irq_sel_o
);
  logic [1:0]       mode_lo_q;
  logic [3:0]       clk_ctl_q;
  logic [CNT_W-1:0] cmp_a_q, cmp_b_q, cnt_w;
  logic [N_EV-1:0]  mask_q, set_w, flags_w, bus_clr_w;
  logic [2:0]       mode_w;
  logic             tick_w, cnt_load_w;

  assign mode_w     = {clk_ctl_q[3], mode_lo_q};
  assign cnt_load_w = wr_en_i && (addr_i == A_COUNT);
  assign bus_clr_w  = (wr_en_i && (addr_i == A_EVENTS)) ? wdata_i[N_EV-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_lo_q <= '0;
      clk_ctl_q <= '0;
      cmp_a_q   <= '0;
      cmp_b_q   <= '0;
      mask_q    <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_MODE_LO: mode_lo_q <= wdata_i[1:0];
        A_CLK_CTL: clk_ctl_q <= wdata_i[3:0];
        A_CMP_A:   cmp_a_q   <= wdata_i;
        A_CMP_B:   cmp_b_q   <= wdata_i;
        A_MASK:    mask_q    <= wdata_i[N_EV-1:0];
        default: ;
      endcase
    end
  end

  tmr_prescaler #(.ALT_TABLE(ALT_TABLE)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cs_i  (clk_ctl_q[2:0]),
    .tick_o(tick_w)
  );

  tmr_count_unit #(.CNT_W(CNT_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_w),
    .load_i    (cnt_load_w),
    .load_val_i(wdata_i),
    .cmp_a_i   (cmp_a_q),
    .cmp_b_i   (cmp_b_q),
    .mode_i    (mode_w),
    .cnt_o     (cnt_w),
    .set_o     (set_w)
  );

  tmr_irq_unit u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_w),
    .bus_clr_i  (bus_clr_w),
    .mask_i     (mask_q),
    .gie_i      (gie_i),
    .ack_i      (irq_ack_i),
    .flags_o    (flags_w),
    .irq_valid_o(irq_valid_o),
    .irq_sel_o  (irq_sel_o)
  );

  always_comb begin
    case (addr_i)
      A_MODE_LO: rdata_o = CNT_W'(mode_lo_q);
      A_CLK_CTL: rdata_o = CNT_W'(clk_ctl_q);
      A_COUNT:   rdata_o = cnt_w;
      A_CMP_A:   rdata_o = cmp_a_q;
      A_CMP_B:   rdata_o = cmp_b_q;
      A_EVENTS:  rdata_o = CNT_W'(flags_w);
      A_MASK:    rdata_o = CNT_W'(mask_q);
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_core_chk.sv
module tmr_core_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gie_i,
  input logic             irq_ack_i,
  input logic             irq_valid_o,
  input logic [1:0]       irq_sel_o,
  input logic             tick_i,
  input logic             cnt_load_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] cmp_a_i,
  input logic [CNT_W-1:0] cmp_b_i,
  input logic [2:0]       mode_i,
  input logic [2:0]       set_i,
  input logic [2:0]       flags_i,
  input logic [2:0]       bus_clr_i
);
  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !cnt_load_i) |=> $stable(cnt_i));

  p_cmp_a_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_a_i == '0) |-> !set_i[1]);

  p_cmp_b_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_b_i == '0) |-> !set_i[2]);

  p_ctc_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i[1] && mode_i == 3'd2) |=> (cnt_i == '0 && flags_i[0]));

  p_flag_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i[0] && !bus_clr_i[0] && !(irq_valid_o && irq_ack_i && irq_sel_o == 2'd0))
    |=> flags_i[0]);

  p_irq_gie_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> gie_i);

  p_sel_legal_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (irq_sel_o != 2'd3));

  p_ack_clear_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_o && irq_ack_i && irq_sel_o == 2'd1 && !set_i[1]) |=> !flags_i[1]);
endmodule

bind tmr_core tmr_core_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .gie_i      (gie_i),
  .irq_ack_i  (irq_ack_i),
  .irq_valid_o(irq_valid_o),
  .irq_sel_o  (irq_sel_o),
  .tick_i     (tick_w),
  .cnt_load_i (cnt_load_w),
  .cnt_i      (cnt_w),
  .cmp_a_i    (cmp_a_q),
  .cmp_b_i    (cmp_b_q),
  .mode_i     (mode_w),
  .set_i      (set_w),
  .flags_i    (flags_w),
  .bus_clr_i  (bus_clr_w)
);

// File: tb/tmr_core_bench.sv
module tmr_ref #(
  parameter int CNT_W = 8,
  parameter bit ALT   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             gie,
  input  logic             ack,
  output logic [CNT_W-1:0] e_rdata,
  output logic             e_valid,
  output logic [1:0]       e_sel
);
  int std_t[8] = '{0, 1, 8, 64, 256, 1024, 0, 0};
  int alt_t[8] = '{1, 1, 8, 32, 64, 128, 256, 1024};
  logic [1:0] ma;
  logic [3:0] cc;
  logic [CNT_W-1:0] cnt, oa, ob, v;
  logic [2:0] flg, msk, csp, set, clr, pend;
  int pc, d, md, s;
  bit chg, tk, ev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ma = 0; cc = 0; cnt = 0; oa = 0; ob = 0; flg = 0; msk = 0; csp = 0; pc = 0;
    end else begin
      d   = ALT ? alt_t[cc[2:0]] : std_t[cc[2:0]];
      chg = (cc[2:0] != csp);
      tk  = (d != 0) && !chg && (pc == d - 1);
      md  = {29'd0, cc[3], ma};
      set = 0; clr = 0; ev = 0; v = cnt;
      if (we && addr == 3'd2) begin
        v = wdata; ev = 1;
      end else if (tk) begin
        v = cnt + 1'b1; ev = 1;
        if (cnt == '1 && (md == 0 || md == 1 || md == 3)) set[0] = 1;
      end
      if (ev && ob != 0 && v == ob) set[2] = 1;
      if (ev && oa != 0 && v == oa) begin
        set[1] = 1;
        if (md == 2) begin set[0] = 1; v = 0; end
      end
      pend = flg & msk & {3{gie}};
      s = pend[0] ? 0 : (pend[1] ? 1 : 2);
      if (ack && pend != 0) clr[s] = 1;
      if (we && addr == 3'd5) clr = clr | wdata[2:0];
      pc  = (d == 0 || chg || tk) ? 0 : pc + 1;
      csp = cc[2:0];
      cnt = v;
      flg = (flg & ~clr) | set;
      if (we) begin
        case (addr)
          3'd0: ma  = wdata[1:0];
          3'd1: cc  = wdata[3:0];
          3'd3: oa  = wdata;
          3'd4: ob  = wdata;
          3'd6: msk = wdata[2:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0: e_rdata = CNT_W'(ma);
      3'd1: e_rdata = CNT_W'(cc);
      3'd2: e_rdata = cnt;
      3'd3: e_rdata = oa;
      3'd4: e_rdata = ob;
      3'd5: e_rdata = CNT_W'(flg);
      3'd6: e_rdata = CNT_W'(msk);
      default: e_rdata = '0;
    endcase
    e_valid = |(flg & msk & {3{gie}});
    e_sel   = (flg[0] & msk[0]) ? 2'd0 : ((flg[1] & msk[1]) ? 2'd1 : 2'd2);
  end
endmodule

module tmr_core_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, gie = 1'b0, ack = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [7:0] rd8, e_rd8;
  logic [15:0] rd16, e_rd16;
  logic v8, v16, ev8, ev16;
  logic [1:0] s8, s16, es8, es16;
  string tag = "R1";
  int n_chk = 0, n_err = 0;
  bit run_chk = 1'b0;
  logic [2:0] rot = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tmr_core #(.CNT_W(8), .ALT_TABLE(1'b0)) u_tmr_core (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr), .wdata_i(wdata[7:0]),
    .rdata_o(rd8), .gie_i(gie), .irq_ack_i(ack), .irq_valid_o(v8), .irq_sel_o(s8));

  tmr_core #(.CNT_W(16), .ALT_TABLE(1'b1)) u_tmr_core_alt (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rd16), .gie_i(gie), .irq_ack_i(ack), .irq_valid_o(v16), .irq_sel_o(s16));

  tmr_ref #(.CNT_W(8), .ALT(1'b0)) u_ref8 (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata[7:0]), .gie(gie),
    .ack(ack), .e_rdata(e_rd8), .e_valid(ev8), .e_sel(es8));

  tmr_ref #(.CNT_W(16), .ALT(1'b1)) u_ref16 (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata), .gie(gie),
    .ack(ack), .e_rdata(e_rd16), .e_valid(ev16), .e_sel(es16));

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD / 4);
    if (run_chk && rst_n) begin
      chk(tag, "rdata", 32'(rd8), 32'(e_rd8));
      chk(tag, "irq_valid", 32'(v8), 32'(ev8));
      if (ev8) chk(tag, "irq_sel", 32'(s8), 32'(es8));
      chk("R13", "alt rdata", 32'(rd16), 32'(e_rd16));
      chk("R13", "alt irq_valid", 32'(v16), 32'(ev16));
      if (ev16) chk("R13", "alt irq_sel", 32'(s16), 32'(es16));
    end
  end

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      we = 1'b0; addr = rot; rot = (rot == 3'd6) ? 3'd0 : rot + 3'd1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 3'd2;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset values, checked while reset is held
    gie = 1'b1;
    #(CLK_PERIOD * 2);
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a);
      #1;
      chk("R1", "reset rdata", 32'(rd8), 32'd0);
      chk("R1", "reset rdata alt", 32'(rd16), 32'd0);
    end
    chk("R1", "reset irq_valid", 32'(v8), 32'd0);
    gie = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    run_chk = 1'b1;

    tag = "R13"; idle(40);

    tag = "R2";
    for (int cs = 1; cs <= 5; cs++) begin
      wr(3'd1, 16'(cs));
      idle((cs == 5) ? 2100 : (cs == 4 ? 600 : 200));
    end
    wr(3'd1, 16'd6); idle(60);
    wr(3'd1, 16'd7); idle(60);
    wr(3'd1, 16'd0); idle(30);

    tag = "R3";
    wr(3'd1, 16'd3); idle(90);
    wr(3'd1, 16'd2); idle(5);
    wr(3'd1, 16'd3); idle(150);
    wr(3'd1, 16'd1); idle(4);

    tag = "R4";
    wr(3'd0, 16'd0); wr(3'd1, 16'd1); idle(560);
    wr(3'd5, 16'd7);
    wr(3'd0, 16'd1); idle(280);
    wr(3'd0, 16'd3); idle(280);
    wr(3'd5, 16'd7);
    wr(3'd0, 16'd2); idle(280);
    wr(3'd1, 16'd9); idle(280);
    wr(3'd1, 16'd1); wr(3'd0, 16'd0); wr(3'd5, 16'd7);

    tag = "R5"; wr(3'd3, 16'd40); idle(300); wr(3'd5, 16'd7);
    tag = "R6"; wr(3'd4, 16'd90); idle(300);
    tag = "R7"; wr(3'd5, 16'd7); wr(3'd0, 16'd2); idle(200);

    tag = "R8";
    wr(3'd1, 16'd0); wr(3'd5, 16'd7);
    wr(3'd2, 16'd40); idle(3);
    wr(3'd0, 16'd0); wr(3'd5, 16'd7);
    wr(3'd2, 16'd90); idle(3);
    wr(3'd2, 16'd39); idle(3);
    wr(3'd1, 16'd1); idle(3);
    wr(3'd2, 16'd200); idle(3);

    tag = "R9";
    wr(3'd1, 16'd0);
    wr(3'd5, 16'd0); idle(2);
    wr(3'd5, 16'd2); idle(2);
    wr(3'd5, 16'd5); idle(2);
    wr(3'd2, 16'd39); wr(3'd5, 16'd0); idle(2);

    tag = "R10";
    wr(3'd2, 16'd40); wr(3'd2, 16'd90);
    wr(3'd6, 16'd7); gie = 1'b0; idle(10);
    gie = 1'b1; idle(10);
    wr(3'd6, 16'd4); idle(10);
    wr(3'd6, 16'd0); idle(10);

    tag = "R11";
    gie = 1'b0; wr(3'd6, 16'd7);
    wr(3'd1, 16'd1); idle(300);
    wr(3'd1, 16'd0); gie = 1'b1; idle(10);

    tag = "R12";
    @(negedge clk); ack = 1'b1;
    idle(1); ack = 1'b0; idle(4);
    ack = 1'b1; idle(1); ack = 1'b0; idle(4);
    ack = 1'b1; idle(3); ack = 1'b0; idle(4);

    tag = "R9";
    process::self().srandom(32'd12345);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      addr = 3'($urandom_range(0, 6));
      we   = ($urandom_range(0, 99) < 20);
      gie  = $urandom_range(0, 1);
      ack  = ($urandom_range(0, 3) == 0);
      case (addr)
        3'd1:         wdata = 16'({$urandom_range(0, 1), 3'($urandom_range(0, 3))});
        3'd3, 3'd4:   wdata = 16'($urandom_range(0, 60));
        3'd2:         wdata = 16'($urandom_range(0, 255));
        default:      wdata = 16'($urandom_range(0, 15));
      endcase
    end
    @(negedge clk); we = 1'b0; ack = 1'b0;
    idle(10);

    finish_run();
  end
endmodule